// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 128 level-sensitive interrupt lines from peripherals, grouped in banks of 32, and presents them to a processor on two outputs: a normal interrupt request line and a fast interrupt line. Software enables each source with a mask bit and picks its output with a route bit. A table of priority slots, each naming one source, is searched every cycle. The result is a status word that names the most urgent enabled source waiting on the normal line, so the interrupt handler does not have to scan bit vectors.

Software reaches every register through a small 32-bit read/write bus. Reads return data one cycle after the request. A wake output tells the clock controller that the system should leave idle. One control bit chooses whether every raised line wakes the system, or only lines that are enabled. There is no data stream at the edges of this block, so the bus and the interrupt pins are plain signals with no back-pressure. Pending state follows the input lines directly. A source is cleared only by removing its cause at the peripheral.

Top module: `prio_intc`

## Requirements
- R1: Bank b (0 to NUM_SRC/32-1) occupies byte addresses b*0x100 onward: normal-pending at +0x00, enable mask at +0x04, route at +0x08, fast-pending at +0x0C, raw lines at +0x10. The control word (+0x14) and the top-priority word (+0x18) exist in bank 0 only. Priority slot s lives at (s/32)*0x100 + 0x1C + 4*(s%32). Unmapped addresses read 0.
- R2: After reset every mask bit, route bit and control bit is 0, every priority slot is invalid, and irq_o and fiq_o are low. Mask bits change only through bus writes.
- R3: A route bit of 1 sends its source to the fast line. Fast-pending reads as raw AND mask AND route. fiq_o is the OR of all fast-pending bits.
- R4: A route bit of 0 sends its source to the normal line. Normal-pending reads as raw AND mask AND NOT route. irq_o is the OR of all normal-pending bits.
- R5: A priority slot word holds the source number in its low bits and a valid flag in bit 31. Among valid slots whose source is normal-pending, the lowest slot index wins. The top-priority word then reads bit 31 = 1 and the source number in bits 30:16, with all other bits 0.
- R6: When no valid slot names a normal-pending source, the top-priority word reads 0.
- R7: With control bit 0 clear, wake_o is high whenever any raw line is high. With it set, wake_o is high only when a raw line that is also enabled is high.
- R8: Raw-pending bits follow the input lines in the same cycle, and no write is needed to clear them.
- R9: Slots whose valid flag is 0 are skipped in the search, even when they name a pending source.
- R10: A read request produces rd_valid high with its data exactly one cycle later. rd_valid is low in every other cycle.
- R11: Writes to the normal-pending, fast-pending, raw and top-priority words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Leave-idle request |

## Verification
The interrupt outputs, the wake output and the raw, pending and top-priority values are combinational in the input lines and the stored registers. A register write is stored on the edge that ends its bus cycle. The bench therefore checks the pins half a cycle after a write completes, or one time unit after the input lines change. Read data arrives one edge after the request. The driver pushes each expected word into a queue, and a monitor pops and compares it on the falling edge after rd_valid rises. Any rd_valid with an empty queue, or a word left in the queue at the end, counts as a failure.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int BANK_SRCS   = 32;
  localparam int BANK_STRIDE = 'h100;
  localparam logic [7:0] OFF_IRQ_PEND = 8'h00;
  localparam logic [7:0] OFF_MASK     = 8'h04;
  localparam logic [7:0] OFF_ROUTE    = 8'h08;
  localparam logic [7:0] OFF_FIQ_PEND = 8'h0C;
  localparam logic [7:0] OFF_RAW      = 8'h10;
  localparam logic [7:0] OFF_CTRL     = 8'h14;
  localparam logic [7:0] OFF_TOP      = 8'h18;
  // slot words occupy word indices 7..38 of each bank window
  localparam logic [5:0] SLOT_WORD_LO = 6'd7;
  localparam logic [5:0] SLOT_WORD_HI = 6'd38;

  function automatic logic is_slot_off(input logic [7:0] off);
    return (off[1:0] == 2'b00) && (off[7:2] >= SLOT_WORD_LO) && (off[7:2] <= SLOT_WORD_HI);
  endfunction

  function automatic logic [4:0] slot_in_bank(input logic [7:0] off);
    logic [5:0] w;
    w = off[7:2] - SLOT_WORD_LO;
    return w[4:0];
  endfunction
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 10,
  localparam int NUM_BANKS = NUM_SRC / BANK_SRCS,
  localparam int SRC_W     = $clog2(NUM_SRC),
  localparam int BANK_W    = ADDR_W - 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [NUM_SRC-1:0]             mask_q,
  output logic [NUM_SRC-1:0]             route_q,
  output logic                           wake_masked_q,
  output logic [NUM_SRC-1:0]             slot_vld_q,
  output logic [NUM_SRC-1:0][SRC_W-1:0]  slot_id_q
);
  logic              wr_en;
  logic [BANK_W-1:0] bank;
  logic [7:0]        off;
  logic              slot_hit;
  logic [4:0]        slot_sub;

  assign wr_en    = bus_sel && bus_wr;
  assign bank     = bus_addr[ADDR_W-1:8];
  assign off      = bus_addr[7:0];
  assign slot_hit = wr_en && is_slot_off(off);
  assign slot_sub = slot_in_bank(off);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[b*BANK_SRCS +: BANK_SRCS]  <= '0;
        route_q[b*BANK_SRCS +: BANK_SRCS] <= '0;
      end else if (wr_en && bank == BANK_W'(b)) begin
        if (off == OFF_MASK)  mask_q[b*BANK_SRCS +: BANK_SRCS]  <= bus_wdata;
        if (off == OFF_ROUTE) route_q[b*BANK_SRCS +: BANK_SRCS] <= bus_wdata;
      end
    end

    for (genvar s = 0; s < BANK_SRCS; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          slot_vld_q[b*BANK_SRCS+s] <= 1'b0;
          slot_id_q[b*BANK_SRCS+s]  <= '0;
        end else if (slot_hit && bank == BANK_W'(b) && slot_sub == 5'(s)) begin
          slot_vld_q[b*BANK_SRCS+s] <= bus_wdata[31];
          slot_id_q[b*BANK_SRCS+s]  <= bus_wdata[SRC_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wake_masked_q <= 1'b0;
    else if (wr_en && bank == '0 && off == OFF_CTRL) wake_masked_q <= bus_wdata[0];
  end
endmodule

// File: rtl/intc_prio_search.sv
module intc_prio_search #(
  parameter int NUM_SRC = 64,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            irq_pend,
  input  logic [NUM_SRC-1:0]            slot_vld,
  input  logic [NUM_SRC-1:0][SRC_W-1:0] slot_id,
  output logic                          top_valid,
  output logic [SRC_W-1:0]              top_id
);
  // walk from the last slot down so the lowest matching index is kept
  always_comb begin
    top_valid = 1'b0;
    top_id    = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (slot_vld[i] && irq_pend[slot_id[i]]) begin
        top_valid = 1'b1;
        top_id    = slot_id[i];
      end
    end
  end
endmodule

// File: rtl/intc_read_port.sv
module intc_read_port
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 10,
  localparam int NUM_BANKS = NUM_SRC / BANK_SRCS,
  localparam int SRC_W     = $clog2(NUM_SRC),
  localparam int BANK_W    = ADDR_W - 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [NUM_SRC-1:0]            raw,
  input  logic [NUM_SRC-1:0]            mask_q,
  input  logic [NUM_SRC-1:0]            route_q,
  input  logic                          wake_masked_q,
  input  logic [NUM_SRC-1:0]            slot_vld,
  input  logic [NUM_SRC-1:0][SRC_W-1:0] slot_id,
  input  logic                          top_valid,
  input  logic [SRC_W-1:0]              top_id,
  output logic                          rd_valid,
  output logic [31:0]                   rd_data
);
  logic [BANK_W-1:0] bank;
  logic [7:0]        off;
  logic [31:0]       word;
  logic [31:0]       r_raw, r_mask, r_route;
  int                bi;
  int                si;

  assign bank = bus_addr[ADDR_W-1:8];
  assign off  = bus_addr[7:0];

  always_comb begin
    word    = '0;
    bi      = int'(bank);
    si      = bi * BANK_SRCS + int'(slot_in_bank(off));
    r_raw   = '0;
    r_mask  = '0;
    r_route = '0;
    if (bi < NUM_BANKS) begin
      r_raw   = raw[bi*BANK_SRCS +: BANK_SRCS];
      r_mask  = mask_q[bi*BANK_SRCS +: BANK_SRCS];
      r_route = route_q[bi*BANK_SRCS +: BANK_SRCS];
      case (off)
        OFF_IRQ_PEND: word = r_raw & r_mask & ~r_route;
        OFF_MASK:     word = r_mask;
        OFF_ROUTE:    word = r_route;
        OFF_FIQ_PEND: word = r_raw & r_mask & r_route;
        OFF_RAW:      word = r_raw;
        OFF_CTRL:     if (bi == 0) word = {31'b0, wake_masked_q};
        OFF_TOP:      if (bi == 0 && top_valid) word = {1'b1, 15'(top_id), 16'b0};
        default:
          if (is_slot_off(off))
            word = {slot_vld[si], 31'(slot_id[si])};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) rd_data <= word;
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               wake_o
);
  localparam int SRC_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]            mask_q, route_q, slot_vld;
  logic [NUM_SRC-1:0][SRC_W-1:0] slot_id;
  logic                          wake_masked_q;
  logic [NUM_SRC-1:0]            irq_pend, fiq_pend;
  logic                          top_valid;
  logic [SRC_W-1:0]              top_id;

  intc_cfg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .mask_q, .route_q, .wake_masked_q,
    .slot_vld_q(slot_vld), .slot_id_q(slot_id)
  );

  assign irq_pend = src_i & mask_q & ~route_q;
  assign fiq_pend = src_i & mask_q & route_q;
  assign irq_o    = |irq_pend;
  assign fiq_o    = |fiq_pend;
  assign wake_o   = wake_masked_q ? |(src_i & mask_q) : |src_i;

  intc_prio_search #(.NUM_SRC(NUM_SRC)) u_search (
    .irq_pend, .slot_vld, .slot_id, .top_valid, .top_id
  );

  intc_read_port #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_rd (
    .clk, .rst, .bus_sel, .bus_wr, .bus_addr,
    .raw(src_i), .mask_q, .route_q, .wake_masked_q,
    .slot_vld, .slot_id, .top_valid, .top_id,
    .rd_valid, .rd_data
  );
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic               irq_o,
  input logic               fiq_o,
  input logic               wake_o,
  input logic               rd_valid,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               top_valid
);
  assert_quiet_after_reset_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && !fiq_o));

  assert_mask_write_only_R2: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr) |=> $stable(mask_q));

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> rd_valid);

  assert_no_spurious_read_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> !rd_valid);

  assert_top_needs_irq_R5: assert property (@(posedge clk) disable iff (rst)
    top_valid |-> irq_o);

  assert_enabled_wakes_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_o || fiq_o) |-> wake_o);
endmodule

bind prio_intc prio_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk, .rst, .bus_sel, .bus_wr, .irq_o, .fiq_o, .wake_o, .rd_valid,
  .mask_q, .top_valid
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int NS = 64;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_i = '0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          rd_valid, irq_o, fiq_o, wake_o;
  logic [31:0]   rd_data;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  prio_intc #(.NUM_SRC(NS), .ADDR_W(AW)) uut (.*);

  always #2 clk = ~clk;

  // monitor: compares each returned read word with the oldest expectation
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected rd_valid actual=%h expected=none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s read actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pin(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s pin actual=%b expected=%b", t, act, e);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R2 reset state
    pin(irq_o, 0, "R2 irq"); pin(fiq_o, 0, "R2 fiq"); pin(wake_o, 0, "R7 idle");
    rd(10'h004, 32'h0, "R2 mask0");
    rd(10'h01C, 32'h0, "R2 slot0");
    rd(10'h018, 32'h0, "R6 empty top");
    // R8 raw lines follow inputs, masked: no irq, wake in any-line mode (R7)
    @(negedge clk); src_i[5] = 1; src_i[40] = 1; #1;
    pin(irq_o, 0, "R4 masked"); pin(wake_o, 1, "R7 any line");
    rd(10'h010, 32'h0000_0020, "R8 raw bank0");
    rd(10'h110, 32'h0000_0100, "R8 raw bank1 R1");
    wr(10'h014, 32'h1);
    pin(wake_o, 0, "R7 masked mode");
    rd(10'h014, 32'h1, "R1 ctrl");
    // R4 enable source 5
    wr(10'h004, 32'h0000_0020);
    pin(irq_o, 1, "R4 irq"); pin(wake_o, 1, "R7 enabled line");
    rd(10'h000, 32'h0000_0020, "R4 irq pend");
    rd(10'h018, 32'h0, "R9 no valid slot");
    // R5 priority: slot0 -> 40, slot1 -> 5
    wr(10'h01C, 32'h8000_0028);
    wr(10'h020, 32'h8000_0005);
    wr(10'h104, 32'h0000_0100);
    rd(10'h020, 32'h8000_0005, "R5 slot word");
    rd(10'h018, 32'h8028_0000, "R5 top is 40");
    // R3 route 40 to fast line
    wr(10'h108, 32'h0000_0100);
    pin(fiq_o, 1, "R3 fiq"); pin(irq_o, 1, "R4 irq kept");
    rd(10'h10C, 32'h0000_0100, "R3 fiq pend");
    rd(10'h100, 32'h0, "R4 bank1 irq pend");
    rd(10'h018, 32'h8005_0000, "R5 top is 5");
    // R9 invalid slot skipped
    wr(10'h108, 32'h0);
    wr(10'h01C, 32'h0000_0028);
    pin(fiq_o, 0, "R3 fiq off");
    rd(10'h018, 32'h8005_0000, "R9 skip invalid");
    // R11 read-only words ignore writes
    wr(10'h000, 32'hFFFF_FFFF);
    wr(10'h018, 32'hFFFF_FFFF);
    wr(10'h010, 32'hFFFF_FFFF);
    rd(10'h000, 32'h0000_0020, "R11 irq pend");
    rd(10'h004, 32'h0000_0020, "R11 mask kept");
    rd(10'h018, 32'h8005_0000, "R11 top");
    // R1 unmapped bank reads 0
    rd(10'h304, 32'h0, "R1 unmapped");
    // R8 level-follow: drop lines, nothing to clear
    @(negedge clk); src_i = '0; #1;
    pin(irq_o, 0, "R8 irq drop"); pin(wake_o, 0, "R8 wake drop");
    rd(10'h018, 32'h0, "R6 empty again");
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule